// File: doc/BRIEF.md
# Paged Pixel Frame Store with Auto-Advancing Write Pointer

This block is the pixel memory of a small monochrome dot-matrix display controller. It is 96 pixels wide and 68 pixels tall. The rows are grouped into horizontal bands of eight, called pages. There are eight full pages and one short bottom page of four rows. A host loads pixels one byte at a time. Each byte fills one column slice of the current page, one bit per row. After each byte the write pointer moves on by itself, so a whole frame can be streamed without re-addressing.

The host side has three single-cycle strobes: select page, select column, and write byte. Select page and select column share one 8-bit value bus. A display scanner reads the memory through its own port. It gives a row and a column and gets back a single pixel one clock later.

Top module: `glcd_frame_store`

## Requirements
- R1: After reset the write pointer is at page 0, column 0, so the first byte written lands in rows 0..7 of column 0.
- R2: A page-select strobe with a value from 0 to 8 moves the pointer to that page, and the next byte written goes there.
- R3: A column-select strobe with a value from 0 to 95 moves the pointer to that column, and the next byte written goes there.
- R4: A page-select value above 8, or a column-select value above 95, is ignored and the pointer keeps its position.
- R5: A written byte stores bit i at row page*8+i of the current column. A stored 1 reads back as a lit pixel (1) and a stored 0 as dark (0).
- R6: A byte write at a column below 95 advances the column by one and keeps the page.
- R7: A byte write at column 95 on pages 0..7 sets the column to 0 and advances the page by one.
- R8: A byte write at column 95 on page 8 returns the pointer to page 0, column 0.
- R9: On page 8 only bits 0..3 are stored, in rows 64..67. Bits 4..7 are dropped.
- R10: The read port returns the pixel at (row, column) one clock after the address is presented. A read and a write to the same cell in the same cycle returns the old value. The output is 0 while in reset.
- R11: A read with a row above 67 or a column above 95 returns 0.
- R12: Strobes are ranked page select first, then column select, then write. When several are high in one cycle, only the highest-ranked one acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_set_i | input | 1 | Strobe: load page pointer from addr_val_i |
| col_set_i | input | 1 | Strobe: load column pointer from addr_val_i |
| wr_en_i | input | 1 | Strobe: store wr_data_i at the pointer, then advance |
| addr_val_i | input | 8 | Page or column value for the select strobes |
| wr_data_i | input | 8 | Pixel byte, bit 0 = top row of the page |
| rd_row_i | input | 7 | Scan read row, 0..67 |
| rd_col_i | input | 7 | Scan read column, 0..95 |
| rd_pix_o | output | 1 | Pixel at the read address, one clock later |

## Verification
The bench builds the block with its default shape: 96 columns, eight full pages and a four-row short page. With this shape a full pass of 864 writes is short enough to clear the whole frame. That pass also exercises the pointer's return to the origin. The same shape puts the half-populated page and the out-of-range row and column codes within easy reach. Out-of-range codes are rows 68 and up and columns 96 and up, both of which the 7-bit read address can express. A reference model in the bench follows the ranking and wrap rules. Every scan read is compared against that model through a queue.

// File: rtl/glcd_fs_pkg.sv
package glcd_fs_pkg;
  localparam int unsigned BYTE_W = 8;

  // rows held by a page bank: full byte, or the short tail page
  function automatic int unsigned bank_width(int unsigned page,
                                             int unsigned full_pages,
                                             int unsigned tail_rows);
    return (page < full_pages) ? BYTE_W : tail_rows;
  endfunction
endpackage

// File: rtl/glcd_fs_rst_sync.sv
module glcd_fs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/glcd_fs_ptr.sv
module glcd_fs_ptr #(
  parameter int unsigned NUM_COLS  = 96,
  parameter int unsigned NUM_PAGES = 9,
  parameter int unsigned COL_W     = 7,
  parameter int unsigned PAGE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_set_i,
  input  logic              col_set_i,
  input  logic              wr_en_i,
  input  logic [7:0]        val_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic              wr_go_o
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              upd_en;
  logic              wr_go;

  always_comb begin
    page_d = page_q;
    col_d  = col_q;
    wr_go  = 1'b0;
    if (page_set_i) begin
      if (val_i <= 8'(NUM_PAGES - 1)) page_d = val_i[PAGE_W-1:0];
    end else if (col_set_i) begin
      if (val_i <= 8'(NUM_COLS - 1)) col_d = val_i[COL_W-1:0];
    end else if (wr_en_i) begin
      wr_go = 1'b1;
      if (col_q == LAST_COL) begin
        col_d  = '0;
        page_d = (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  assign upd_en = page_set_i | col_set_i | wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (upd_en) begin
      page_q <= page_d;
      col_q  <= col_d;
    end
  end

  assign page_o  = page_q;
  assign col_o   = col_q;
  assign wr_go_o = wr_go;
endmodule

// File: rtl/glcd_fs_bank.sv
module glcd_fs_bank #(
  parameter int unsigned DEPTH = 96,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 7
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/glcd_frame_store.sv
module glcd_frame_store
  import glcd_fs_pkg::*;
#(
  parameter int unsigned NUM_COLS   = 96,
  parameter int unsigned FULL_PAGES = 8,
  parameter int unsigned TAIL_ROWS  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       page_set_i,
  input  logic       col_set_i,
  input  logic       wr_en_i,
  input  logic [7:0] addr_val_i,
  input  logic [7:0] wr_data_i,
  input  logic [6:0] rd_row_i,
  input  logic [6:0] rd_col_i,
  output logic       rd_pix_o
);
  localparam int unsigned NUM_PAGES = FULL_PAGES + 1;
  localparam int unsigned NUM_ROWS  = FULL_PAGES * BYTE_W + TAIL_ROWS;
  localparam int unsigned COL_W     = 7;
  localparam int unsigned ROW_W     = 7;
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES);
  localparam int unsigned PG_IDX_W  = ROW_W - 3;

  logic              rst_n_sync;
  logic [PAGE_W-1:0] ptr_page;
  logic [COL_W-1:0]  ptr_col;
  logic              wr_go;
  logic [BYTE_W-1:0] bank_rd [NUM_PAGES];
  logic              rd_in_range;
  logic [COL_W-1:0]  rd_col_safe;
  logic [PG_IDX_W-1:0] rd_page;
  logic [2:0]        rd_bit;
  logic              pix_d, rd_pix_q;

  glcd_fs_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  glcd_fs_ptr #(
    .NUM_COLS  (NUM_COLS),
    .NUM_PAGES (NUM_PAGES),
    .COL_W     (COL_W),
    .PAGE_W    (PAGE_W)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .page_set_i (page_set_i),
    .col_set_i  (col_set_i),
    .wr_en_i    (wr_en_i),
    .val_i      (addr_val_i),
    .page_o     (ptr_page),
    .col_o      (ptr_col),
    .wr_go_o    (wr_go)
  );

  assign rd_in_range = (rd_row_i < ROW_W'(NUM_ROWS)) && (rd_col_i < COL_W'(NUM_COLS));
  assign rd_col_safe = rd_in_range ? rd_col_i : '0;
  assign rd_page     = rd_row_i[ROW_W-1:3];
  assign rd_bit      = rd_row_i[2:0];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    localparam int unsigned W = bank_width(p, FULL_PAGES, TAIL_ROWS);
    logic [W-1:0] rd_w;

    glcd_fs_bank #(
      .DEPTH (NUM_COLS),
      .WIDTH (W),
      .AW    (COL_W)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_go && (ptr_page == PAGE_W'(p))),
      .waddr_i (ptr_col),
      .wdata_i (wr_data_i[W-1:0]),
      .raddr_i (rd_col_safe),
      .rdata_o (rd_w)
    );

    assign bank_rd[p] = BYTE_W'(rd_w);
  end

  always_comb begin
    pix_d = 1'b0;
    for (int q = 0; q < NUM_PAGES; q++) begin
      if (rd_in_range && (rd_page == PG_IDX_W'(q))) pix_d = bank_rd[q][rd_bit];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) rd_pix_q <= 1'b0;
    else             rd_pix_q <= pix_d;
  end

  assign rd_pix_o = rd_pix_q;
endmodule

// File: rtl/glcd_frame_store_chk.sv
module glcd_frame_store_chk #(
  parameter int unsigned NUM_COLS  = 96,
  parameter int unsigned NUM_PAGES = 9,
  parameter int unsigned NUM_ROWS  = 68,
  parameter int unsigned COL_W     = 7,
  parameter int unsigned PAGE_W    = 4
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              page_set_i,
  input logic              col_set_i,
  input logic              wr_en_i,
  input logic [7:0]        addr_val_i,
  input logic [6:0]        rd_row_i,
  input logic [6:0]        rd_col_i,
  input logic              rd_pix_o,
  input logic [PAGE_W-1:0] cur_page,
  input logic [COL_W-1:0]  cur_col
);
  localparam logic [COL_W-1:0]  LCOL  = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] LPAGE = PAGE_W'(NUM_PAGES - 1);

  logic do_wr;
  assign do_wr = wr_en_i && !page_set_i && !col_set_i;

  // R3
  col_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cur_col <= LCOL);

  // R2
  page_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cur_page <= LPAGE);

  // R6
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (do_wr && cur_col != LCOL) |=>
      (cur_col == $past(cur_col) + 1'b1) && (cur_page == $past(cur_page)));

  // R7
  page_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (do_wr && cur_col == LCOL && cur_page != LPAGE) |=>
      (cur_col == '0) && (cur_page == $past(cur_page) + 1'b1));

  // R8
  full_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (do_wr && cur_col == LCOL && cur_page == LPAGE) |=>
      (cur_col == '0) && (cur_page == '0));

  // R4
  bad_page_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (page_set_i && addr_val_i > 8'(NUM_PAGES - 1)) |=>
      $stable(cur_page) && $stable(cur_col));

  // R4
  bad_col_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!page_set_i && col_set_i && addr_val_i > 8'(NUM_COLS - 1)) |=>
      $stable(cur_page) && $stable(cur_col));

  // R12
  page_rank_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (page_set_i && addr_val_i <= 8'(NUM_PAGES - 1)) |=>
      (cur_page == $past(addr_val_i[PAGE_W-1:0])) && $stable(cur_col));

  // R11
  rd_oob_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_row_i >= 7'(NUM_ROWS) || rd_col_i >= 7'(NUM_COLS)) |=> !rd_pix_o);
endmodule

bind glcd_frame_store glcd_frame_store_chk #(
  .NUM_COLS  (NUM_COLS),
  .NUM_PAGES (NUM_PAGES),
  .NUM_ROWS  (NUM_ROWS),
  .COL_W     (COL_W),
  .PAGE_W    (PAGE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .page_set_i (page_set_i),
  .col_set_i  (col_set_i),
  .wr_en_i    (wr_en_i),
  .addr_val_i (addr_val_i),
  .rd_row_i   (rd_row_i),
  .rd_col_i   (rd_col_i),
  .rd_pix_o   (rd_pix_o),
  .cur_page   (ptr_page),
  .cur_col    (ptr_col)
);

// File: tb/glcd_frame_store_bench.sv
module glcd_frame_store_bench;
  localparam int NC = 96;
  localparam int NR = 68;
  localparam int LASTPG = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       page_set, col_set, wr_en;
  logic [7:0] addr_val, wr_data;
  logic [6:0] rd_row, rd_col;
  logic       rd_pix;

  always #5 clk = ~clk;

  glcd_frame_store u_glcd_frame_store (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .page_set_i (page_set),
    .col_set_i  (col_set),
    .wr_en_i    (wr_en),
    .addr_val_i (addr_val),
    .wr_data_i  (wr_data),
    .rd_row_i   (rd_row),
    .rd_col_i   (rd_col),
    .rd_pix_o   (rd_pix)
  );

  typedef struct {
    bit    exp;
    int    row;
    int    col;
    string tag;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mdl [NR][NC];
  int mpage = 0;
  int mcol = 0;

  function automatic bit ref_pix(int r, int c);
    return (r < NR && c < NC) ? mdl[r][c] : 1'b0;
  endfunction

  // model of a byte store and pointer advance (R5, R6, R7, R8, R9)
  function automatic void model_write(int d);
    for (int i = 0; i < 8; i++) begin
      if (mpage < LASTPG || i < 4) mdl[mpage*8 + i][mcol] = d[i];
    end
    if (mcol == NC - 1) begin
      mcol  = 0;
      mpage = (mpage == LASTPG) ? 0 : mpage + 1;
    end else begin
      mcol = mcol + 1;
    end
  endfunction

  // strobe ranking (R12) and range filter (R4)
  function automatic void model_apply(bit ps, bit cs, bit we, int val, int d);
    if (ps) begin
      if (val <= LASTPG) mpage = val;
    end else if (cs) begin
      if (val <= NC - 1) mcol = val;
    end else if (we) begin
      model_write(d);
    end
  endfunction

  task automatic op(bit ps, bit cs, bit we, int val, int d);
    @(negedge clk);
    page_set = ps; col_set = cs; wr_en = we;
    addr_val = 8'(val); wr_data = 8'(d);
    model_apply(ps, cs, we, val, d);
    @(negedge clk);
    page_set = 1'b0; col_set = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_page(int v); op(1'b1, 1'b0, 1'b0, v, 0); endtask
  task automatic set_col(int v);  op(1'b0, 1'b1, 1'b0, v, 0); endtask
  task automatic wr_byte(int d);  op(1'b0, 1'b0, 1'b1, 0, d); endtask

  // driver side of the scoreboard: present a read, queue its expected pixel
  task automatic rd(int r, int c, string tag);
    item_t it;
    @(negedge clk);
    rd_row = 7'(r);
    rd_col = 7'(c);
    it.exp = ref_pix(r, c); it.row = r; it.col = c; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chk_byte(int pg, int c, string tag);
    for (int i = 0; i < 8; i++) begin
      if (pg*8 + i < NR) rd(pg*8 + i, c, tag);
    end
  endtask

  // write and read in one cycle; the read expects the old value (R10)
  task automatic wr_and_read(int d, int r, int c);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'(d);
    rd_row = 7'(r); rd_col = 7'(c);
    it.exp = ref_pix(r, c); it.row = r; it.col = c; it.tag = "R10 same-cycle";
    sbq.push_back(it);
    model_write(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_cmp++;
      if (rd_pix !== it.exp) begin
        n_bad++;
        $display("FAIL %s: row %0d col %0d actual %b expected %b",
                 it.tag, it.row, it.col, rd_pix, it.exp);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    page_set = 1'b0; col_set = 1'b0; wr_en = 1'b0;
    addr_val = '0; wr_data = '0; rd_row = '0; rd_col = '0;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (rd_pix !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: rd_pix actual %b expected 0", rd_pix);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: first byte after reset goes to page 0 column 0; the rest clear the
    // frame, and 864 writes bring the pointer back to the origin (R8)
    wr_byte(8'hA5);
    for (int k = 1; k < 9*NC; k++) wr_byte(8'h00);
    chk_byte(0, 0, "R1 origin");
    chk_byte(8, 95, "R9 cleared tail");

    // R2 R3 R5 R6: explicit addressing, then auto-increment
    set_page(3); set_col(10);
    wr_byte(8'h3C); wr_byte(8'hFF);
    chk_byte(3, 10, "R5 bit order");
    chk_byte(3, 11, "R6 increment");
    chk_byte(3, 12, "R6 untouched");

    // R9: short page keeps low nibble only
    set_page(8); set_col(5);
    wr_byte(8'hFF); wr_byte(8'hF0);
    chk_byte(8, 5, "R9 low nibble");
    chk_byte(8, 6, "R9 high nibble dropped");

    // R7: page carry at the last column
    set_page(2); set_col(95);
    wr_byte(8'h81); wr_byte(8'h42);
    chk_byte(2, 95, "R7 last column");
    chk_byte(3, 0, "R7 carry");

    // R8: full wrap from the last address
    set_page(8); set_col(95);
    wr_byte(8'h0F); wr_byte(8'h11);
    chk_byte(8, 95, "R8 last address");
    chk_byte(0, 0, "R8 wrap to origin");

    // R4: out-of-range selects leave the pointer alone
    set_page(1); set_col(20);
    set_page(9); set_page(255); set_col(96); set_col(127);
    wr_byte(8'h77);
    chk_byte(1, 20, "R4 ignored select");

    // R12: strobe ranking
    set_page(0); set_col(30);
    op(1'b1, 1'b1, 1'b1, 5, 8'hFF);
    op(1'b0, 1'b1, 1'b1, 40, 8'hFF);
    set_col(30);
    wr_byte(8'h0F);
    chk_byte(0, 30, "R12 no write under page select");
    chk_byte(5, 30, "R12 page wins");
    chk_byte(5, 40, "R12 no write under column select");

    // R10: same-cycle read and write return the old value
    set_page(6); set_col(50);
    wr_and_read(8'h01, 48, 50);
    rd(48, 50, "R10 new value");

    // R11: out-of-range reads return 0
    set_page(0); set_col(0); wr_byte(8'hFF);
    rd(68, 0, "R11 row 68");
    rd(127, 0, "R11 row 127");
    rd(0, 96, "R11 col 96");
    rd(3, 127, "R11 col 127");
    rd(3, 0, "R5 lit pixel");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule